// File: doc/BRIEF.md
# CAN Bit Stuffing Codec

This block applies the CAN bit-stuffing rule to serial bit streams, one bit per bit-time strobe. The transmit half sits between a framer's bit source and the bus driver. Whenever the line has carried a run of `RUN_LEN` identical bits (five by default), it inserts one bit of the opposite level. For that slot it holds the bit source by lowering its ready output. The receive half sits after the bit sampler. It removes the inserted bits and reports a stuff error when the level that should have been inserted is missing.

Stuffing applies only inside a span that the framer marks with a region-enable input, one for each direction. That span runs from start of frame through the CRC sequence. The CRC delimiter, the acknowledge bits and the end-of-frame bits lie outside it and pass through untouched. A stuff bit counts as the first bit of the run that follows it. Dropping a region-enable clears that direction's run history at once, whether or not a strobe is present.

Levels follow the bus convention: 0 is dominant and 1 is recessive.

Top module: `can_stuff_codec`

## Requirements
- R1: While reset is held and right after it, `tx_bit_out` is 1 (recessive), `tx_ready` is 1 with `tx_region` low, and `rx_bit_valid` and `rx_stuff_err` are 0.
- R2: With `tx_region` high, the slot that follows five identical line bits carries a stuff bit. `tx_ready` is 0 during that slot, the source bit offered in it is not consumed, and that same source bit goes out in the next slot.
- R3: A transmitted stuff bit is the complement of the run that precedes it.
- R4: On transmit, the stuff bit is the first bit of the next run. For example, source 00000 then 11111 produces the line 00000 1 1111 0 1.
- R5: With `tx_region` low, no stuff bit is inserted and `tx_ready` stays 1. Each source bit goes out unchanged, even in runs longer than five.
- R6: A low region-enable clears that direction's run count, even in a cycle without a strobe. After it, a full new run of five is needed before the next stuff slot.
- R7: With `rx_region` high, the bit in the slot after five identical bits is removed: `rx_bit_valid` stays 0 for it. Every other bit appears on `rx_bit_out` with `rx_bit_valid` high for one cycle.
- R8: With `rx_region` high, a sixth identical bit in the stuff slot raises `rx_stuff_err` for one cycle, without `rx_bit_valid`. That bit then starts a new run of one.
- R9: With `rx_region` low, every bit is delivered with `rx_bit_valid`, and runs of any length raise no error.
- R10: On receive, a removed stuff bit counts as the first bit of the next run. In the input 00000 1 1111 1, the final 1 is a stuff error.
- R11: `tx_bit_out` changes only at a clock edge where `bit_tick` is sampled high. `rx_bit_valid` and `rx_stuff_err` pulse only in the cycle after such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_tick | input | 1 | One-cycle strobe per bit time, shared by both directions |
| tx_region | input | 1 | High while transmitted bits fall in the stuffed span |
| tx_src_bit | input | 1 | Next bit offered by the bit source |
| tx_ready | output | 1 | 1 when the current slot takes `tx_src_bit`; 0 during a stuff slot |
| tx_bit_out | output | 1 | Bit driven toward the bus, updated on each strobe |
| rx_region | input | 1 | High while received bits fall in the stuffed span |
| rx_bit_in | input | 1 | Sampled bus bit for the current strobe |
| rx_bit_valid | output | 1 | One-cycle pulse: `rx_bit_out` holds a data bit |
| rx_bit_out | output | 1 | Last received bit |
| rx_stuff_err | output | 1 | One-cycle pulse on a stuffing violation |

## Verification
The bench loops the expected line stream back into the receiver. The run that follows a stuff bit has to end one source bit early. A codec that restarted counting at zero after inserting would stuff one slot late on transmit and miss the error in the input 00000 1 1111 1. Separate sequences drop the region-enable for one cycle without a strobe between two runs of the same level. A design that waited for a strobe to clear its count would then stuff, or flag an error, too early. Runs longer than five outside the region check that the end-of-frame bits are neither stuffed nor flagged. A sixth identical bit followed by a different bit checks that the receiver reports the error once and then resumes delivering data.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;

  // Identical bits allowed on the line before a complement is forced.
  localparam int unsigned STUFF_RUN_DEFAULT = 5;

  // Classification of one received slot.
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_DROP  = 2'd2,
    SLOT_FAULT = 2'd3
  } rx_slot_e;

endpackage

// File: rtl/can_run_tracker.sv
module can_run_tracker #(
  parameter int unsigned RUN_LEN = 5,
  parameter int unsigned CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  input  logic bit_in,
  output logic last_bit,
  output logic run_full
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_q, last_d;
  logic             cnt_en;

  assign run_full = (cnt_q == CNT_FULL);
  assign last_bit = last_q;
  assign cnt_en   = clear | step;

  // A full run never extends: the next bit, stuffed or faulty, opens a new run.
  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    if (clear) begin
      cnt_d = '0;
    end else if (step) begin
      last_d = bit_in;
      if ((cnt_q != '0) && (bit_in == last_q) && !run_full) begin
        cnt_d = cnt_q + CNT_ONE;
      end else begin
        cnt_d = CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/can_stuff_tx.sv
module can_stuff_tx #(
  parameter int unsigned RUN_LEN = 5,
  parameter int unsigned CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic region,
  input  logic src_bit,
  output logic src_ready,
  output logic line_bit
);

  logic last_bit, run_full;
  logic stuff_slot;
  logic emit_bit;
  logic line_q, line_d;

  assign stuff_slot = region & run_full;
  assign emit_bit   = stuff_slot ? ~last_bit : src_bit;
  assign src_ready  = ~stuff_slot;

  can_run_tracker #(
    .RUN_LEN (RUN_LEN),
    .CNT_W   (CNT_W)
  ) i_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (bit_tick),
    .clear    (~region),
    .bit_in   (emit_bit),
    .last_bit (last_bit),
    .run_full (run_full)
  );

  always_comb begin
    line_d = line_q;
    if (bit_tick) begin
      line_d = emit_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
    end else if (bit_tick) begin
      line_q <= line_d;
    end
  end

  assign line_bit = line_q;

endmodule

// File: rtl/can_destuff_rx.sv
module can_destuff_rx
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LEN = 5,
  parameter int unsigned CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic region,
  input  logic line_bit,
  output logic data_valid,
  output logic data_bit,
  output logic stuff_err
);

  logic     last_bit, run_full;
  rx_slot_e slot_kind;
  logic     valid_q, valid_d;
  logic     err_q, err_d;
  logic     bit_q, bit_d;

  can_run_tracker #(
    .RUN_LEN (RUN_LEN),
    .CNT_W   (CNT_W)
  ) i_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (bit_tick),
    .clear    (~region),
    .bit_in   (line_bit),
    .last_bit (last_bit),
    .run_full (run_full)
  );

  always_comb begin
    if (!bit_tick) begin
      slot_kind = SLOT_IDLE;
    end else if (!region) begin
      slot_kind = SLOT_DATA;
    end else if (run_full) begin
      slot_kind = (line_bit == last_bit) ? SLOT_FAULT : SLOT_DROP;
    end else begin
      slot_kind = SLOT_DATA;
    end
  end

  always_comb begin
    valid_d = (slot_kind == SLOT_DATA);
    err_d   = (slot_kind == SLOT_FAULT);
    bit_d   = bit_tick ? line_bit : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      bit_q   <= 1'b1;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      bit_q   <= bit_d;
    end
  end

  assign data_valid = valid_q;
  assign stuff_err  = err_q;
  assign data_bit   = bit_q;

endmodule

// File: rtl/can_stuff_codec.sv
module can_stuff_codec
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LEN = STUFF_RUN_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_region,
  input  logic tx_src_bit,
  output logic tx_ready,
  output logic tx_bit_out,
  input  logic rx_region,
  input  logic rx_bit_in,
  output logic rx_bit_valid,
  output logic rx_bit_out,
  output logic rx_stuff_err
);

  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

  can_stuff_tx #(
    .RUN_LEN (RUN_LEN),
    .CNT_W   (CNT_W)
  ) i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .region    (tx_region),
    .src_bit   (tx_src_bit),
    .src_ready (tx_ready),
    .line_bit  (tx_bit_out)
  );

  can_destuff_rx #(
    .RUN_LEN (RUN_LEN),
    .CNT_W   (CNT_W)
  ) i_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .region     (rx_region),
    .line_bit   (rx_bit_in),
    .data_valid (rx_bit_valid),
    .data_bit   (rx_bit_out),
    .stuff_err  (rx_stuff_err)
  );

endmodule

// File: rtl/can_stuff_codec_chk.sv
module can_stuff_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_region,
  input logic tx_ready,
  input logic tx_bit_out,
  input logic rx_region,
  input logic rx_bit_valid,
  input logic rx_stuff_err
);

  // R3: a stuff slot drives the complement of the bit on the line.
  a_r3_stuff_is_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !tx_ready) |=> (tx_bit_out != $past(tx_bit_out)));

  // R4: the stuff bit opens a new run, so the next slot is never a stuff slot.
  a_r4_no_back_to_back_stuff: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !tx_ready) |=> tx_ready);

  // R5: outside the stuffed span the source is never held.
  a_r5_ready_outside_region: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_region |-> tx_ready);

  // R8: an error pulse lasts one cycle and carries no data.
  a_r8_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |=> !rx_stuff_err);

  a_r8_err_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> !rx_bit_valid);

  // R9: outside the stuffed span every strobed bit is delivered.
  a_r9_outside_region_delivers: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rx_region) |=> (rx_bit_valid && !rx_stuff_err));

  // R11: without a strobe nothing moves.
  a_r11_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_bit_out));

  a_r11_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> (!rx_bit_valid && !rx_stuff_err));

endmodule

bind can_stuff_codec can_stuff_codec_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .tx_region    (tx_region),
  .tx_ready     (tx_ready),
  .tx_bit_out   (tx_bit_out),
  .rx_region    (rx_region),
  .rx_bit_valid (rx_bit_valid),
  .rx_stuff_err (rx_stuff_err)
);

// File: tb/test_can_stuff_codec.sv
module test_can_stuff_codec;

  localparam int CLK_PERIOD = 10;
  localparam int K_DATA = 1;
  localparam int K_DROP = 0;
  localparam int K_ERR  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic tx_region = 1'b0;
  logic tx_src_bit = 1'b1;
  logic tx_ready;
  logic tx_bit_out;
  logic rx_region = 1'b0;
  logic rx_bit_in = 1'b1;
  logic rx_bit_valid;
  logic rx_bit_out;
  logic rx_stuff_err;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    logic  line;
    logic  rdy;
    int    kind;
    logic  rxb;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  can_stuff_codec i_can_stuff_codec (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .tx_region    (tx_region),
    .tx_src_bit   (tx_src_bit),
    .tx_ready     (tx_ready),
    .tx_bit_out   (tx_bit_out),
    .rx_region    (rx_region),
    .rx_bit_in    (rx_bit_in),
    .rx_bit_valid (rx_bit_valid),
    .rx_bit_out   (rx_bit_out),
    .rx_stuff_err (rx_stuff_err)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  // Driver: one slot, strobe high for the next capturing edge.
  task automatic drive_slot(input logic txr, input logic sb, input logic exp_line,
                            input logic exp_rdy, input logic rxr, input logic rxb,
                            input int exp_kind, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    tx_region  = txr;
    tx_src_bit = sb;
    rx_region  = rxr;
    rx_bit_in  = rxb;
    bit_tick   = 1'b1;
    e.line = exp_line;
    e.rdy  = exp_rdy;
    e.kind = exp_kind;
    e.rxb  = rxb;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // Strobe off, both regions low for a full cycle (clears run history).
  task automatic idle_clear();
    @(posedge clk);
    #2;
    bit_tick  = 1'b0;
    tx_region = 1'b0;
    rx_region = 1'b0;
    @(posedge clk);
    #2;
  endtask

  // Transmit sequence with the expected line looped back into the receiver.
  task automatic tx_seq(input logic reg_on, input logic [31:0] src, input int nsrc,
                        input logic [31:0] line, input logic [31:0] rdy,
                        input int nslot, input string tag);
    int si;
    si = 0;
    for (int k = 0; k < nslot; k++) begin
      logic sb, lb, rb;
      sb = (si < nsrc) ? src[nsrc-1-si] : 1'b1;
      lb = line[nslot-1-k];
      rb = rdy[nslot-1-k];
      drive_slot(reg_on, sb, lb, rb, reg_on, lb, rb ? K_DATA : K_DROP, tag);
      if (rb) si++;
    end
  endtask

  // Receive-only sequence; transmitter idles recessive outside its region.
  task automatic rx_seq(input logic [31:0] bits, input logic [31:0] errm,
                        input logic [31:0] dropm, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int kd;
      kd = errm[n-1-k] ? K_ERR : (dropm[n-1-k] ? K_DROP : K_DATA);
      drive_slot(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, bits[n-1-k], kd, tag);
    end
  endtask

  // Monitor: tx_ready sampled mid-cycle while the strobe is high, the
  // registered outputs one cycle later, against the scoreboard head.
  logic pend = 1'b0;
  logic rdy_s = 1'b1;
  always @(negedge clk) begin
    exp_t e;
    if (pend) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R11", "scoreboard empty", 0, 1);
      end else begin
        e = sb_q.pop_front();
        check(tx_bit_out === e.line, e.tag, "tx_bit_out", int'(tx_bit_out), int'(e.line));
        check(rdy_s === e.rdy, e.tag, "tx_ready", int'(rdy_s), int'(e.rdy));
        check(rx_bit_valid === (e.kind == K_DATA), e.tag, "rx_bit_valid",
              int'(rx_bit_valid), int'(e.kind == K_DATA));
        check(rx_stuff_err === (e.kind == K_ERR), e.tag, "rx_stuff_err",
              int'(rx_stuff_err), int'(e.kind == K_ERR));
        if (e.kind == K_DATA)
          check(rx_bit_out === e.rxb, e.tag, "rx_bit_out", int'(rx_bit_out), int'(e.rxb));
      end
      pend = 1'b0;
    end
    if (bit_tick === 1'b1) begin
      rdy_s = tx_ready;
      pend  = 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic held;
    // R1: reset state, during and after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_bit_out === 1'b1, "R1", "tx_bit_out in reset", int'(tx_bit_out), 1);
    check(rx_bit_valid === 1'b0, "R1", "rx_bit_valid in reset", int'(rx_bit_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_bit_out === 1'b1, "R1", "tx_bit_out", int'(tx_bit_out), 1);
    check(tx_ready === 1'b1, "R1", "tx_ready", int'(tx_ready), 1);
    check(rx_bit_valid === 1'b0, "R1", "rx_bit_valid", int'(rx_bit_valid), 0);
    check(rx_stuff_err === 1'b0, "R1", "rx_stuff_err", int'(rx_stuff_err), 0);

    // R2 / R7: zeros run, stuff 1, held source bit follows
    tx_seq(1'b1, 32'b0000001, 7, 32'b00000101, 32'b11111011, 8, "R2_R7");
    idle_clear();
    // R3: ones run gets a dominant stuff bit
    tx_seq(1'b1, 32'b1111111, 7, 32'b11111011, 32'b11111011, 8, "R3");
    idle_clear();
    // R4: stuff bit opens the next run
    tx_seq(1'b1, 32'b0000011111, 10, 32'b000001111101, 32'b111110111101, 12, "R4");
    idle_clear();
    // R6: region drop without a strobe clears both run counts
    tx_seq(1'b1, 32'b0000, 4, 32'b0000, 32'b1111, 4, "R6");
    idle_clear();
    tx_seq(1'b1, 32'b000000, 6, 32'b0000010, 32'b1111101, 7, "R6");
    idle_clear();
    // R5 / R9: outside the region long runs pass untouched
    tx_seq(1'b0, 32'b1111111, 7, 32'b1111111, 32'b1111111, 7, "R5_R9");
    tx_seq(1'b0, 32'b0000000, 7, 32'b0000000, 32'b1111111, 7, "R5_R9");
    idle_clear();
    // R8: sixth identical bit is an error, next bit is data again
    rx_seq(32'b0000001, 32'b0000010, 32'b0000000, 7, "R8");
    idle_clear();
    // R10: removed stuff bit counts toward the next run
    rx_seq(32'b00000111111, 32'b00000000001, 32'b00000100000, 11, "R10");
    idle_clear();

    // R11: no strobe, nothing moves
    held = tx_bit_out;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tx_bit_out === held, "R11", "tx_bit_out held", int'(tx_bit_out), int'(held));
      check(!rx_bit_valid && !rx_stuff_err, "R11", "rx pulses idle",
            int'(rx_bit_valid | rx_stuff_err), 0);
    end
    check(sb_q.size() == 0, "R11", "scoreboard drained", sb_q.size(), 0);

    summary();
    $finish;
  end

endmodule